// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits in the decode stage of a five-stage pipeline and holds the control half of the decode/execute register. When the instruction now in execute is a load, and its target register (the rt field) is read by the instruction in decode as either source, the block stalls for one cycle. Both the program-counter write enable and the fetch/decode write enable drop, so fetch and decode repeat their instructions. An all-zero control word enters execute in place of the decode word. That bubble reads no memory, writes no memory, writes no register and carries ALU op 00.

After the single bubble the load has reached the memory stage. The dependent instruction then reaches execute one cycle behind it and gets the loaded value from the memory/writeback forwarding path, so the hazard never needs a second stall. The execute-stage memory-read flag is taken from the block's own registered control word. Only the execute rt field comes from the datapath half of the register.

Top module: `lu_stall_unit`

## Requirements
- R1: The stall is raised in a cycle exactly when the registered execute control word has its memory-read bit (bit 5) set and `ex_rt` equals `id_rs` or `id_rt`.
- R2: When the memory-read bit of the execute control word is clear, a register match between `ex_rt` and a decode source raises no stall.
- R3: `pc_we` is 0 in a stall cycle and 1 in every other cycle.
- R4: `ifid_we` is 0 in a stall cycle and 1 in every other cycle.
- R5: After a stall cycle the execute control word `ex_ctrl` is all zeros. Its layout is [7] register write, [6] memory-to-register, [5] memory read, [4] memory write, [3] branch, [2] ALU source, [1:0] ALU op.
- R6: After a cycle without a stall and without reset, `ex_ctrl` equals the `id_ctrl` value driven in that cycle.
- R7: A stall never lasts more than one cycle. When the decode instruction is held unchanged, the cycle after a stall does not stall.
- R8: When a load is followed by a second load whose base register (`id_rs`) is the first load's target, the pipeline stalls exactly once. The second load then enters execute with its memory-read bit set.
- R9: A low `rst_n` at a clock edge clears `ex_ctrl` to zero, regardless of any stall in that cycle. When the clear takes effect, the block shows no stall.
- R10: A load followed by an instruction that reads neither of the load's target registers causes no stall.
- R11: `bubble` is 1 exactly in stall cycles, so it is always the complement of `pc_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_ctrl | input | 8 | Control word decoded for the instruction in decode |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| ex_rt | input | 5 | rt field of the instruction in execute |
| pc_we | output | 1 | Program-counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | High while the zero control word is selected |
| ex_ctrl | output | 8 | Registered control word of the execute stage |

## Verification
A synchronous reset can fall in the same cycle as a stall. In that cycle `ex_ctrl` would be zeroed both by the reset and by the bubble, but the enables must still drop. The bench provokes this by loading a word with the memory-read bit set and then asserting reset while decode presents a matching source. It requires `pc_we` and `ifid_we` low before the edge and `ex_ctrl` zero after it. On the cycle after reset is released, with decode unchanged, it requires that no stall appears.

// File: rtl/lu_pkg.sv
// Package lu_pkg
// Shared widths and the control-word layout used by the stall unit.
// Assumes a 32-entry register file and an 8-bit control word.
package lu_pkg;
    parameter int REG_AW = 5;

    // Control word carried into the execute stage (MSB first).
    typedef struct packed {
        logic       reg_wr;
        logic       mem_to_reg;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic       alu_src;
        logic [1:0] alu_op;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam ctrl_t CTRL_NOP = '0;
endpackage

// File: rtl/lu_match_detect.sv
// Module lu_match_detect
// Compares the execute-stage target register with every decode source.
// Raises hazard when the execute instruction reads memory and any source matches.
// Assumes: purely combinational, register 0 is not treated specially.
module lu_match_detect #(
    parameter int AW      = lu_pkg::REG_AW,
    parameter int NUM_SRC = 2
) (
    input  logic                  ex_is_load,
    input  logic [AW-1:0]         ex_dst,
    input  logic [NUM_SRC*AW-1:0] id_srcs,
    output logic                  hazard
);
    logic [NUM_SRC-1:0] hit;

    // One comparator per decode source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign hit[g] = (id_srcs[g*AW +: AW] == ex_dst);
    end

    // Hazard only when the execute instruction is a load.
    always_comb begin
        hazard = ex_is_load && (|hit);
    end
endmodule

// File: rtl/lu_stall_gen.sv
// Module lu_stall_gen
// Turns the hazard flag into the three pipeline controls.
// Assumes a single-cycle stall: the caller guarantees hazard clears next cycle.
module lu_stall_gen (
    input  logic hazard,
    output logic pc_we,
    output logic ifid_we,
    output logic zero_sel
);
    // Freeze fetch and decode and select the bubble while a hazard is seen.
    always_comb begin
        pc_we    = !hazard;
        ifid_we  = !hazard;
        zero_sel = hazard;
    end
endmodule

// File: rtl/lu_ctrl_reg.sv
// Module lu_ctrl_reg
// Zeroing mux plus the decode/execute control register.
// Assumes synchronous active-low reset; reset has priority over the mux.
module lu_ctrl_reg #(
    parameter int W = lu_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_sel,
    input  logic [W-1:0] d_ctrl,
    output logic [W-1:0] q_ctrl
);
    logic [W-1:0] next_ctrl;

    // Pick the decode word or the all-zero bubble.
    always_comb begin
        next_ctrl = zero_sel ? '0 : d_ctrl;
    end

    // Register the chosen word into the execute stage.
    always_ff @(posedge clk) begin
        if (!rst_n) q_ctrl <= '0;
        else        q_ctrl <= next_ctrl;
    end

    // R5: a selected bubble lands as zero.
    p_bubble_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_sel |=> (q_ctrl == '0));

    // R6: without a bubble the decode word is captured.
    p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_sel |=> (q_ctrl == $past(d_ctrl)));
endmodule

// File: rtl/lu_stall_unit.sv
// Module lu_stall_unit
// Load-use stall unit: detects a load in execute feeding a decode source,
// holds PC and fetch/decode for one cycle and inserts a zero control bubble.
// Assumes the execute memory-read flag is bit mem_rd of its own register.
module lu_stall_unit #(
    parameter int AW = lu_pkg::REG_AW,
    parameter int CW = lu_pkg::CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] id_ctrl,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rt,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          bubble,
    output logic [CW-1:0] ex_ctrl
);
    import lu_pkg::*;

    localparam int NSRC = 2;

    ctrl_t            ex_word;
    logic             hazard;
    logic [NSRC*AW-1:0] srcs;

    // View the registered word through the shared layout.
    always_comb begin
        ex_word = ctrl_t'(ex_ctrl);
        srcs    = {id_rt, id_rs};
    end

    lu_match_detect #(.AW(AW), .NUM_SRC(NSRC)) u_det (
        .ex_is_load (ex_word.mem_rd),
        .ex_dst     (ex_rt),
        .id_srcs    (srcs),
        .hazard     (hazard)
    );

    lu_stall_gen u_gen (
        .hazard   (hazard),
        .pc_we    (pc_we),
        .ifid_we  (ifid_we),
        .zero_sel (bubble)
    );

    lu_ctrl_reg #(.W(CW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_sel (bubble),
        .d_ctrl   (id_ctrl),
        .q_ctrl   (ex_ctrl)
    );

    // R2: no stall unless execute holds a load.
    p_needs_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> ex_word.mem_rd);

    // R7: a stall is never followed by another stall.
    p_single_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    // R3 / R4: both enables move together.
    p_we_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we == ifid_we);

    // R11: bubble select is the complement of the PC enable.
    p_bubble_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bubble != pc_we);

    // R9: leaving reset, execute starts empty.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ex_ctrl == '0));
endmodule

// File: tb/sim_lu_stall_unit.sv
`timescale 1ns/1ps
module sim_lu_stall_unit;
    localparam logic [7:0] C_LW  = 8'hE4;
    localparam logic [7:0] C_SW  = 8'h14;
    localparam logic [7:0] C_R   = 8'h82;
    localparam logic [7:0] C_BEQ = 8'h09;
    localparam int NV = 15;

    // {ctrl, rs, rt, ex_rt, expect_stall, expect_ex_ctrl_after_edge}
    localparam logic [31:0] VEC [NV] = '{
        {C_R,   5'd2,  5'd3,  5'd0,  1'b0, C_R  },  // v0  R6
        {C_LW,  5'd1,  5'd2,  5'd1,  1'b0, C_LW },  // v1  R2 match but no load
        {C_R,   5'd2,  5'd5,  5'd2,  1'b1, 8'h00},  // v2  R1 rs match
        {C_R,   5'd2,  5'd5,  5'd2,  1'b0, C_R  },  // v3  R7 repeat
        {C_LW,  5'd2,  5'd7,  5'd5,  1'b0, C_LW },  // v4
        {C_R,   5'd6,  5'd7,  5'd7,  1'b1, 8'h00},  // v5  R1 rt match
        {C_R,   5'd6,  5'd7,  5'd7,  1'b0, C_R  },  // v6  R7
        {C_LW,  5'd3,  5'd4,  5'd7,  1'b0, C_LW },  // v7
        {C_R,   5'd9,  5'd10, 5'd4,  1'b0, C_R  },  // v8  R10 independent
        {C_LW,  5'd1,  5'd1,  5'd10, 1'b0, C_LW },  // v9
        {C_LW,  5'd1,  5'd4,  5'd1,  1'b1, 8'h00},  // v10 R8 base dependency
        {C_LW,  5'd1,  5'd4,  5'd1,  1'b0, C_LW },  // v11 R8 once only
        {C_SW,  5'd4,  5'd8,  5'd4,  1'b1, 8'h00},  // v12 R1 after load-load
        {C_SW,  5'd4,  5'd8,  5'd4,  1'b0, C_SW },  // v13
        {C_BEQ, 5'd0,  5'd0,  5'd0,  1'b0, C_BEQ}   // v14
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] id_ctrl = '0;
    logic [4:0] id_rs = '0, id_rt = '0, ex_rt = '0;
    logic       pc_we, ifid_we, bubble;
    logic [7:0] ex_ctrl;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lu_stall_unit u0 (
        .clk(clk), .rst_n(rst_n), .id_ctrl(id_ctrl), .id_rs(id_rs),
        .id_rt(id_rt), .ex_rt(ex_rt), .pc_we(pc_we), .ifid_we(ifid_we),
        .bubble(bubble), .ex_ctrl(ex_ctrl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_stall(input string req, input logic st);
        chk({req, " pc_we R3"},   32'(pc_we),   32'(!st));
        chk({req, " ifid_we R4"}, 32'(ifid_we), 32'(!st));
        chk({req, " bubble R11"}, 32'(bubble),  32'(st));
    endtask

    initial begin
        // Reset state R9
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset ex_ctrl", 32'(ex_ctrl), 32'h0);
        chk_stall("R9 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10 R11
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            id_ctrl = VEC[i][31:24];
            id_rs   = VEC[i][23:19];
            id_rt   = VEC[i][18:14];
            ex_rt   = VEC[i][13:9];
            #1;
            chk_stall($sformatf("R1 v%0d", i), VEC[i][8]);
            @(posedge clk);
            #1;
            chk($sformatf("R5/R6 v%0d ex_ctrl", i), 32'(ex_ctrl), 32'(VEC[i][7:0]));
        end

        // Directed: reset in the same cycle as a stall (R9)
        @(negedge clk);
        id_ctrl = C_LW; id_rs = 5'd3; id_rt = 5'd12; ex_rt = 5'd0;
        @(posedge clk); #1;
        chk("R6 load enters", 32'(ex_ctrl), 32'(C_LW));
        @(negedge clk);
        rst_n = 1'b0; id_ctrl = C_R; id_rs = 5'd20; id_rt = 5'd12; ex_rt = 5'd12;
        #1;
        chk_stall("R1 stall with reset low", 1'b1);
        @(posedge clk); #1;
        chk("R9 reset beats stall", 32'(ex_ctrl), 32'h0);
        chk_stall("R9 after clear", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_stall("R7 held decode after reset", 1'b0);
        @(posedge clk); #1;
        chk("R6 after reset release", 32'(ex_ctrl), 32'(C_R));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule